// File: doc/BRIEF.md
# Asymmetric Carrier PWM Generator for a Z-Source Buck+Boost Inverter

This block makes the PWM carrier and the seven gate signals for an inverter fed from an impedance (Z-source) network with a buck transistor in front of it. The period is a programmable number of clocks. Each period splits into a rising and a falling part. In buck and buck-boost operation, the share of the rising part is the buck duty divided by one minus the shoot-through duty. The carrier climbs from zero to full scale over the rising part and drops back to zero over the falling part. The buck gate is on during the rising part, so the inverter's volt-seconds come only from the intervals in which the intermediate voltage is present.

In boost operation the falling part would be zero, which would turn the carrier into a sawtooth and make every leg switch at the same instant. In that mode the block uses a symmetric triangle instead and holds the buck gate on. Each of the six transistor gates compares the carrier with its own duty word. High-side gates use a strict less-than comparison. Low-side gates use less-than-or-equal, so that where a leg's two duties overlap, the leg is shorted on purpose (shoot-through).

All inputs are taken only at the last clock of a period. The rise length is also computed at that point and held for the whole of the next period. The transistor duties themselves are computed upstream, and dead time is applied downstream.

Top module: `zsrc_carrier_pwm`

## Requirements
- R1: While reset is asserted, all six transistor gates and the buck gate are low and the carrier equals full scale FS = 2^DW.
- R2: The period N is taken from `period_i` at each wrap, with values below 2 treated as 2. The period counter steps through 0..N-1, and each count lasts one clock.
- R3: `mode_i`, `period_i`, `duty_a_i`, `duty_b_i` and `duty_ph_i` are sampled only in the last clock of a period. Changes at any other time have no effect on the outputs.
- R4: In buck and buck-boost modes, the rise length is R = floor((2·dA·N + D) / (2·D)), clamped to at most N. Here D = FS − dBe, with dBe = 0 in buck mode and dBe = dB in buck-boost mode. This is dA·N/D rounded half up.
- R5: In boost mode, R = floor(N/2) regardless of the duties, and the buck gate stays high for the whole period.
- R6: With fall length F = N − R, at count c the carrier is floor(c·FS/R) for c < R and floor((N−c)·FS/F) otherwise.
- R7: High-side gates are bits 0, 2 and 4 of `gate_ph_o`. Each is high while the carrier is strictly below its duty field. The field for gate k is `duty_ph_i[k*DW +: DW]`, zero-extended.
- R8: Low-side gates are bits 1, 3 and 5. Each is high while the carrier is at or below its own duty field.
- R9: In buck and buck-boost modes, the buck gate is high exactly while the count is below R.
- R10: The mode is encoded as 2'b00 buck, 2'b01 boost, and 2'b10 or 2'b11 buck-boost. In buck mode `duty_b_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Operating mode (buck, boost, buck-boost) |
| period_i | input | CW | Switching period in clocks |
| duty_a_i | input | DW | Buck (active) duty, fraction of 2^DW |
| duty_b_i | input | DW | Shoot-through duty, fraction of 2^DW |
| duty_ph_i | input | 6*DW | Six transistor duty words, gate k at bits k*DW |
| carrier_o | output | DW+1 | Present carrier value, 0..2^DW |
| gate_ph_o | output | 6 | Transistor gates; even bits high-side, odd bits low-side |
| gate_buck_o | output | 1 | Buck transistor gate |

## Verification
The bench builds the block with DW = 6 and CW = 7, so full scale is 64 and periods run from 2 to 127 clocks. At that size, short periods of 10 to 16 clocks make every carrier step visible. They also make an exact half-way rounding tie on the rise length reachable, along with the clamp where the buck duty exceeds one minus the shoot-through duty. Duty words of 0 and 63 hit both comparator extremes, and a period request of 1 exercises the minimum-period floor.

// File: rtl/zsp_pkg.sv
package zsp_pkg;
    typedef enum logic [1:0] {
        MD_BUCK     = 2'b00,
        MD_BOOST    = 2'b01,
        MD_BBST     = 2'b10,
        MD_BBST_ALT = 2'b11
    } mode_e;

    localparam int NGATE = 6;
endpackage

// File: rtl/zsp_rise_calc.sv
module zsp_rise_calc
    import zsp_pkg::*;
#(
    parameter int CW = 8,
    parameter int DW = 8
) (
    input  mode_e          mode,
    input  logic [CW-1:0]  per,
    input  logic [DW-1:0]  da,
    input  logic [DW-1:0]  db,
    output logic [CW-1:0]  rise
);
    localparam int PW = CW + DW + 3;
    localparam logic [DW:0] FS = (DW+1)'(1) << DW;

    logic [DW:0]   den;
    logic [PW-1:0] num;
    logic [PW-1:0] quo;

    always_comb begin
        // R10: buck mode ignores the shoot-through duty
        den  = (mode == MD_BUCK) ? FS : FS - (DW+1)'(db);
        num  = ((PW'(da) * PW'(per)) << 1) + PW'(den);
        quo  = num / (PW'(den) << 1);
        if (mode == MD_BOOST) begin
            rise = per >> 1;                       // R5 symmetric fallback
        end else if (quo > PW'(per)) begin
            rise = per;                            // R4 clamp
        end else begin
            rise = CW'(quo);
        end
    end
endmodule

// File: rtl/zsp_carrier.sv
module zsp_carrier #(
    parameter int CW = 8,
    parameter int DW = 8
) (
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] per,
    input  logic [CW-1:0] rise,
    output logic [DW:0]   car
);
    localparam int PW = CW + DW + 1;
    localparam logic [DW:0] FS = (DW+1)'(1) << DW;

    logic [CW-1:0] fall;
    logic [PW-1:0] quo;

    always_comb begin
        fall = per - rise;
        quo  = '0;
        if (cnt < rise) begin
            quo = (PW'(cnt) << DW) / PW'(rise);
            car = (DW+1)'(quo);
        end else if (fall != '0) begin
            quo = (PW'(per - cnt) << DW) / PW'(fall);
            car = (DW+1)'(quo);
        end else begin
            car = FS;
        end
    end
endmodule

// File: rtl/zsp_gate_cmp.sv
module zsp_gate_cmp
    import zsp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW:0]          car,
    input  logic [NGATE*DW-1:0]  duty,
    output logic [NGATE-1:0]     gate
);
    localparam int NLEG = NGATE / 2;

    for (genvar k = 0; k < NGATE; k++) begin : g_cmp
        logic [DW:0] ref_w;
        assign ref_w = {1'b0, duty[k*DW +: DW]};
        if (k % 2 == 0) begin : g_hi
            assign gate[k] = car < ref_w;          // R7
        end else begin : g_lo
            assign gate[k] = car <= ref_w;         // R8
        end
    end

    for (genvar l = 0; l < NLEG; l++) begin : g_leg
        always_comb begin
            // R8: low duty >= high duty means the low side covers the high side
            p_leg_overlap_r8: assert (!(gate[2*l] &&
                (duty[(2*l+1)*DW +: DW] >= duty[2*l*DW +: DW])) || gate[2*l+1])
                else $error("leg %0d low side missing during overlap", l);
        end
    end
endmodule

// File: rtl/zsrc_carrier_pwm.sv
module zsrc_carrier_pwm
    import zsp_pkg::*;
#(
    parameter int CW = 8,
    parameter int DW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode_i,
    input  logic [CW-1:0]        period_i,
    input  logic [DW-1:0]        duty_a_i,
    input  logic [DW-1:0]        duty_b_i,
    input  logic [6*DW-1:0]      duty_ph_i,
    output logic [DW:0]          carrier_o,
    output logic [5:0]           gate_ph_o,
    output logic                 gate_buck_o
);
    localparam logic [DW:0]   FS     = (DW+1)'(1) << DW;
    localparam logic [CW-1:0] PERMIN = CW'(2);

    typedef struct packed {
        logic [CW-1:0]        cnt;
        logic [CW-1:0]        per;
        logic [CW-1:0]        rise;
        mode_e                mode;
        logic [NGATE*DW-1:0]  duty;
    } st_t;

    st_t           st_d, st_q;
    logic          wrap;
    logic [CW-1:0] per_in;
    logic [CW-1:0] rise_in;
    mode_e         mode_in;

    assign mode_in = mode_e'(mode_i);
    assign per_in  = (period_i < PERMIN) ? PERMIN : period_i;   // R2
    assign wrap    = (st_q.cnt == st_q.per - CW'(1));

    zsp_rise_calc #(.CW(CW), .DW(DW)) u_rise (
        .mode (mode_in),
        .per  (per_in),
        .da   (duty_a_i),
        .db   (duty_b_i),
        .rise (rise_in)
    );

    always_comb begin
        st_d = st_q;
        if (wrap) begin                           // R3: sample only here
            st_d.cnt  = '0;
            st_d.per  = per_in;
            st_d.rise = rise_in;
            st_d.mode = mode_in;
            st_d.duty = duty_ph_i;
        end else begin
            st_d.cnt  = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.per  <= CW'(1);
            st_q.rise <= '0;
            st_q.mode <= MD_BUCK;
            st_q.duty <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    zsp_carrier #(.CW(CW), .DW(DW)) u_car (
        .cnt  (st_q.cnt),
        .per  (st_q.per),
        .rise (st_q.rise),
        .car  (carrier_o)
    );

    zsp_gate_cmp #(.DW(DW)) u_cmp (
        .car  (carrier_o),
        .duty (st_q.duty),
        .gate (gate_ph_o)
    );

    assign gate_buck_o = (st_q.mode == MD_BOOST) ? 1'b1 : (st_q.cnt < st_q.rise);

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < st_q.per);

    p_hold_mid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> ($stable(st_q.duty) && $stable(st_q.rise) &&
                   $stable(st_q.per) && $stable(st_q.mode)));

    p_boost_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MD_BOOST) |-> (st_q.rise == (st_q.per >> 1)));

    p_peak_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == st_q.rise) |-> (carrier_o == FS));

    p_sa_rising_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode != MD_BOOST && gate_buck_o) |-> (carrier_o < FS));
endmodule

// File: tb/sim_zsrc_carrier_pwm.sv
`timescale 1ns/1ps
module sim_zsrc_carrier_pwm;
    localparam int CW = 7;
    localparam int DW = 6;
    localparam int FS = 1 << DW;

    typedef struct {
        int    car;
        int    gates;
        int    sa;
        int    cyc;
        string note;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        mode_i = '0;
    logic [CW-1:0]     period_i = '0;
    logic [DW-1:0]     duty_a_i = '0;
    logic [DW-1:0]     duty_b_i = '0;
    logic [6*DW-1:0]   duty_ph_i = '0;
    logic [DW:0]       carrier_o;
    logic [5:0]        gate_ph_o;
    logic              gate_buck_o;

    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    zsrc_carrier_pwm #(.CW(CW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .period_i(period_i),
        .duty_a_i(duty_a_i), .duty_b_i(duty_b_i), .duty_ph_i(duty_ph_i),
        .carrier_o(carrier_o), .gate_ph_o(gate_ph_o), .gate_buck_o(gate_buck_o)
    );

    task automatic check(bit ok, string req, string what, int got, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // monitor: compare one expected item per cycle
    always @(negedge clk) begin
        if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(int'(carrier_o) == e.car, "R6",
                  $sformatf("%s carrier c=%0d", e.note, e.cyc), int'(carrier_o), e.car);
            check(int'(gate_ph_o & 6'b010101) == (e.gates & 'b010101), "R7",
                  $sformatf("%s high gates c=%0d", e.note, e.cyc), int'(gate_ph_o), e.gates);
            check(int'(gate_ph_o & 6'b101010) == (e.gates & 'b101010), "R8",
                  $sformatf("%s low gates c=%0d", e.note, e.cyc), int'(gate_ph_o), e.gates);
            check(int'(gate_buck_o) == e.sa, "R9/R5",
                  $sformatf("%s buck gate c=%0d", e.note, e.cyc), int'(gate_buck_o), e.sa);
        end
    end

    // driver: program one period, push its expectations, wait it out
    task automatic run_period(int md, int n, int da, int db, int d[6],
                              bit scramble, string note);
        int ne, dbe, den, r, f, car, g;
        ne  = (n < 2) ? 2 : n;                             // R2
        dbe = (md == 0) ? 0 : db;                          // R10
        den = FS - dbe;
        if (md == 1) r = ne / 2;                           // R5
        else begin
            r = (2 * da * ne + den) / (2 * den);           // R4
            if (r > ne) r = ne;
        end
        f = ne - r;
        for (int c = 0; c < ne; c++) begin
            exp_t e;
            car = (c < r) ? (c * FS) / r : ((ne - c) * FS) / f;
            g = 0;
            for (int k = 0; k < 6; k++) begin
                if (k % 2 == 0 && car <  d[k]) g |= (1 << k);
                if (k % 2 == 1 && car <= d[k]) g |= (1 << k);
            end
            e.car = car; e.gates = g; e.cyc = c; e.note = note;
            e.sa = (md == 1) ? 1 : int'(c < r);
            q.push_back(e);
        end
        mode_i   = 2'(md);
        period_i = CW'(n);
        duty_a_i = DW'(da);
        duty_b_i = DW'(db);
        for (int k = 0; k < 6; k++) duty_ph_i[k*DW +: DW] = DW'(d[k]);
        for (int k = 0; k < ne; k++) begin
            @(negedge clk);
            if (scramble && k == ne / 2) begin
                #1;                                        // R3 mid-period noise
                mode_i = 2'b01; period_i = CW'(3);
                duty_a_i = DW'(5); duty_b_i = DW'(50);
                duty_ph_i = '1;
            end
        end
        #1;
    endtask

    initial begin
        int d1[6] = '{10, 40, 33, 33, 63, 0};
        int d2[6] = '{0, 0, 63, 63, 20, 25};
        int d3[6] = '{32, 31, 1, 2, 50, 50};
        repeat (3) @(negedge clk);
        // R1 reset state
        check(int'(carrier_o) == FS, "R1", "reset carrier", int'(carrier_o), FS);
        check(gate_ph_o == 6'b0, "R1", "reset gates", int'(gate_ph_o), 0);
        check(gate_buck_o == 1'b0, "R1", "reset buck gate", int'(gate_buck_o), 0);
        rst_n = 1'b1;
        #1;
        run_period(0, 10, 32, 40, d1, 0, "R4 buck exact, R10 dB ignored");
        run_period(0, 10, 16, 0,  d2, 0, "R4 buck half tie");
        run_period(2, 12, 20, 16, d3, 0, "R4 buck-boost");
        run_period(3, 12, 20, 16, d1, 0, "R10 alt buck-boost code");
        run_period(1, 11, 40, 30, d1, 0, "R5 boost triangle");
        run_period(0, 1,  32, 0,  d3, 0, "R2 short period floor");
        run_period(0, 16, 48, 0,  d1, 1, "R3 scrambled mid period");
        run_period(0, 16, 48, 0,  d1, 0, "R3 after scramble");
        run_period(0, 9,  0,  0,  d2, 0, "R6 zero rise");
        run_period(2, 9,  60, 20, d3, 0, "R4 clamp full rise");
        run_period(1, 14, 0,  0,  d2, 0, "R5 boost extremes");
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule